// File: doc/BRIEF.md
# Burst Flash Bus Address Front-End

This block is the device-side front end of a 16-bit flash memory bus, running in a fast system clock domain. The bus pins (chip select, address hold strobe, bus clock, pin reset, write strobe, address and data) arrive asynchronously. They are brought into the system domain by a synchronizer chain, and edges are found by comparing each synchronized sample with the one before it.

Reads run in one of two modes. In asynchronous mode the read address register is transparent while the hold strobe is low and freezes while it is high. In synchronous (burst) mode the address is taken only on a chosen bus clock edge while the hold strobe is low. After that, a latency counter drives a WAIT output and its own tri-state enable. Writes capture address and data on whichever rising edge comes first, write strobe or chip select. Mode, clock polarity, WAIT timing and latency come in as static configuration inputs. The mode is adopted at the start of each access.

Top module: `flash_bus_frontend`

## Requirements
- R1: While `rst` is high every output is driven to 0. This includes `wait_oe`, `wait_o`, `data_valid`, `sync_mode`, `wr_stb`, `rd_addr`, `wr_addr` and `wr_data`.
- R2: While `pin_rst_n` is low, the following are all 0: `wait_oe`, `wait_o`, `data_valid`, `sync_mode` and `rd_addr`. Any burst in progress is abandoned. After release the block is in asynchronous mode (`sync_mode`=0).
- R3: After `pin_rst_n` is released, `data_valid` stays 0 until a falling edge of `pin_ce_n` or of `pin_ahold` has been seen.
- R4: In asynchronous mode, `rd_addr` follows `pin_addr` while `pin_ahold`=0 and holds its value while `pin_ahold`=1. Bus clock edges have no effect on it.
- R5: In synchronous mode, `rd_addr` loads `pin_addr` only on a selected bus clock edge while `pin_ahold`=0. The selected edge is rising when `cfg_clk_rise`=1 and falling when it is 0. Without such an edge, `rd_addr` keeps its value.
- R6: The effective latency is L = `cfg_latency` clamped to the range 2..7. `data_valid` becomes 1 after the L-th selected edge following the capture edge, and not before.
- R7: With `cfg_wait_early`=0, `wait_o` is 1 while fewer than L selected edges have followed capture. With `cfg_wait_early`=1, it is 1 while fewer than L-1 have followed. Before any capture, `wait_o` is 0.
- R8: `wait_oe` is 1 exactly while the bus is active (`pin_ce_n`=0 and `pin_rst_n`=1). `wait_o` is 0 whenever `wait_oe` is 0.
- R9: A write produces exactly one `wr_stb` pulse. The pulse carries `pin_addr`/`pin_data` into `wr_addr`/`wr_data` on the first rising edge of `pin_we_n` or `pin_ce_n`. While `pin_we_n`=0, bus clock edges capture no address.
- R10: `sync_mode` loads `cfg_sync_mode` on each falling edge of `pin_ce_n`. It does not change during an access.
- R11: Every output reflects a pin change within four system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| pin_ce_n | input | 1 | Chip select, active low |
| pin_ahold | input | 1 | Address hold strobe: 0 transparent, 1 hold |
| pin_bclk | input | 1 | Bus clock |
| pin_rst_n | input | 1 | Bus-side reset, active low |
| pin_we_n | input | 1 | Write strobe, active low |
| pin_addr | input | AW | Address lines |
| pin_data | input | DW | Write data lines |
| cfg_clk_rise | input | 1 | 1: capture on rising bus clock edge, 0: falling |
| cfg_wait_early | input | 1 | 1: WAIT released one bus cycle early |
| cfg_sync_mode | input | 1 | 1: synchronous burst reads |
| cfg_latency | input | 3 | First-data latency in bus cycles |
| rd_addr | output | AW | Captured read address |
| wr_addr | output | AW | Captured write address |
| wr_data | output | DW | Captured write data |
| wr_stb | output | 1 | One-cycle pulse per captured write |
| sync_mode | output | 1 | Mode adopted for the current access |
| data_valid | output | 1 | Read data may be presented |
| wait_o | output | 1 | WAIT level, 1 = not ready |
| wait_oe | output | 1 | Tri-state enable for WAIT |

## Verification
Burst reads are driven from a vector table that covers both clock polarities and both WAIT timings. The table uses latencies of 2, 3 and 7, plus a value of 1 that must clamp to 2. Comparing normal and early rows with the same latency isolates the one-cycle WAIT shift. Comparing the polarity rows shows that the unselected edge neither captures nor counts. Directed sequences cover the asynchronous latch (transparent, held, and clock toggles ignored), and writes ended first by the write strobe and first by chip select. A pin reset dropped mid-burst is followed by release without a fresh chip-select edge, which separates the data-valid gating from the plain active condition.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  typedef struct packed {
    logic ce_n;
    logic ahold;
    logic bclk;
    logic rst_n;
    logic we_n;
  } fbf_pins_t;

  localparam fbf_pins_t PINS_IDLE = '{ce_n: 1'b1, ahold: 1'b1, bclk: 1'b0,
                                      rst_n: 1'b0, we_n: 1'b1};

  localparam int unsigned LAT_MIN = 2;

  function automatic logic [2:0] lat_clamp(input logic [2:0] raw);
    return (raw < 3'(LAT_MIN)) ? 3'(LAT_MIN) : raw;
  endfunction

endpackage

// File: rtl/fbf_sync.sv
module fbf_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/fbf_addr_capture.sv
module fbf_addr_capture #(
  parameter int unsigned AW = 22,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rst_pin_s,
  input  logic          active,
  input  logic          mode_sync,
  input  logic          ahold_s,
  input  logic          we_n_s,
  input  logic          we_rise,
  input  logic          ce_rise,
  input  logic          sel_edge,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  output logic          cap_stb,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_stb
);

  logic wr_armed;

  // burst capture: selected edge, strobe open, read cycle, active bus
  assign cap_stb = active & mode_sync & we_n_s & sel_edge & ~ahold_s;

  always_ff @(posedge clk) begin
    if (rst || !rst_pin_s) begin
      rd_addr <= '0;
    end else if (!mode_sync) begin
      if (!ahold_s) rd_addr <= addr_s;
    end else if (cap_stb) begin
      rd_addr <= addr_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rst_pin_s) begin
      wr_armed <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (wr_armed && (we_rise || ce_rise)) begin
        wr_addr  <= addr_s;
        wr_data  <= data_s;
        wr_stb   <= 1'b1;
        wr_armed <= 1'b0;
      end else if (active && !we_n_s) begin
        wr_armed <= 1'b1;
      end
    end
  end

  assert_hold_keeps_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (ahold_s && rst_pin_s) |=> $stable(rd_addr))
    else $error("R4: read address moved while hold strobe high");

  assert_single_write_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb)
    else $error("R9: write strobe longer than one cycle");

endmodule

// File: rtl/fbf_burst_ctrl.sv
module fbf_burst_ctrl
  import fbf_pkg::*;
#(
  parameter int unsigned LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_pin_s,
  input  logic             active,
  input  logic             we_n_s,
  input  logic             ce_fall,
  input  logic             ahold_fall,
  input  logic             sel_edge,
  input  logic             cap_stb,
  input  logic             cfg_sync_mode,
  input  logic             cfg_wait_early,
  input  logic [LAT_W-1:0] cfg_latency,
  output logic             mode_sync,
  output logic             data_valid,
  output logic             wait_o,
  output logic             wait_oe
);

  logic [LAT_W-1:0] cnt;
  logic             started;
  logic             seen_fall;
  logic             wait_lvl;

  // remaining edges before first data; early release one edge sooner
  assign wait_lvl = cfg_wait_early ? (cnt >= LAT_W'(2)) : (cnt >= LAT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !rst_pin_s) begin
      mode_sync  <= 1'b0;
      seen_fall  <= 1'b0;
      cnt        <= '0;
      started    <= 1'b0;
      data_valid <= 1'b0;
      wait_o     <= 1'b0;
      wait_oe    <= 1'b0;
    end else begin
      if (ce_fall) mode_sync <= cfg_sync_mode;
      seen_fall <= seen_fall | ce_fall | ahold_fall;

      if (!active) begin
        cnt     <= '0;
        started <= 1'b0;
      end else if (cap_stb) begin
        cnt     <= lat_clamp(cfg_latency);
        started <= 1'b1;
      end else if (sel_edge && we_n_s && mode_sync && cnt != '0) begin
        cnt <= cnt - LAT_W'(1);
      end

      wait_oe    <= active;
      wait_o     <= active & mode_sync & started & wait_lvl;
      data_valid <= active & seen_fall & we_n_s &
                    (mode_sync ? (started & (cnt == '0)) : 1'b1);
    end
  end

  assert_wait_needs_oe_R8: assert property (@(posedge clk) disable iff (rst)
    wait_o |-> wait_oe)
    else $error("R8: WAIT driven while its enable is off");

  assert_pin_reset_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !rst_pin_s |=> (!data_valid && !wait_oe && !mode_sync))
    else $error("R2: outputs not quiet under pin reset");

  assert_lat_floor_R6: assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> (cnt >= LAT_W'(2)))
    else $error("R6: latency below floor after capture");

  assert_valid_after_wait_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid) && mode_sync |-> !wait_o)
    else $error("R7: data flagged valid while WAIT high");

endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
  import fbf_pkg::*;
#(
  parameter int unsigned AW          = 22,
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_ce_n,
  input  logic          pin_ahold,
  input  logic          pin_bclk,
  input  logic          pin_rst_n,
  input  logic          pin_we_n,
  input  logic [AW-1:0] pin_addr,
  input  logic [DW-1:0] pin_data,
  input  logic          cfg_clk_rise,
  input  logic          cfg_wait_early,
  input  logic          cfg_sync_mode,
  input  logic [2:0]    cfg_latency,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_stb,
  output logic          sync_mode,
  output logic          data_valid,
  output logic          wait_o,
  output logic          wait_oe
);

  localparam int unsigned PW = $bits(fbf_pins_t);
  localparam int unsigned BW = AW + DW;

  fbf_pins_t       pins_raw, pins_s, pins_prev;
  logic [PW-1:0]   pins_s_vec;
  logic [BW-1:0]   bus_s;
  logic [AW-1:0]   addr_s;
  logic [DW-1:0]   data_s;

  assign pins_raw = '{ce_n: pin_ce_n, ahold: pin_ahold, bclk: pin_bclk,
                      rst_n: pin_rst_n, we_n: pin_we_n};

  fbf_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync_ctl (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s_vec)
  );

  fbf_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst(rst), .d({pin_addr, pin_data}), .q(bus_s)
  );

  assign pins_s = fbf_pins_t'(pins_s_vec);
  assign {addr_s, data_s} = bus_s;

  always_ff @(posedge clk) begin
    if (rst) pins_prev <= PINS_IDLE;
    else     pins_prev <= pins_s;
  end

  logic ce_fall, ce_rise, ahold_fall, bclk_rise, bclk_fall, we_rise;
  logic sel_edge, active, cap_stb;

  assign ce_fall    =  pins_prev.ce_n  & ~pins_s.ce_n;
  assign ce_rise    = ~pins_prev.ce_n  &  pins_s.ce_n;
  assign ahold_fall =  pins_prev.ahold & ~pins_s.ahold;
  assign bclk_rise  = ~pins_prev.bclk  &  pins_s.bclk;
  assign bclk_fall  =  pins_prev.bclk  & ~pins_s.bclk;
  assign we_rise    = ~pins_prev.we_n  &  pins_s.we_n;
  assign sel_edge   = cfg_clk_rise ? bclk_rise : bclk_fall;
  assign active     = ~pins_s.ce_n & pins_s.rst_n;

  fbf_addr_capture #(.AW(AW), .DW(DW)) u_addr (
    .clk(clk), .rst(rst), .rst_pin_s(pins_s.rst_n), .active(active),
    .mode_sync(sync_mode), .ahold_s(pins_s.ahold), .we_n_s(pins_s.we_n),
    .we_rise(we_rise), .ce_rise(ce_rise), .sel_edge(sel_edge),
    .addr_s(addr_s), .data_s(data_s), .cap_stb(cap_stb),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb(wr_stb)
  );

  fbf_burst_ctrl #(.LAT_W(3)) u_burst (
    .clk(clk), .rst(rst), .rst_pin_s(pins_s.rst_n), .active(active),
    .we_n_s(pins_s.we_n), .ce_fall(ce_fall), .ahold_fall(ahold_fall),
    .sel_edge(sel_edge), .cap_stb(cap_stb), .cfg_sync_mode(cfg_sync_mode),
    .cfg_wait_early(cfg_wait_early), .cfg_latency(cfg_latency),
    .mode_sync(sync_mode), .data_valid(data_valid), .wait_o(wait_o),
    .wait_oe(wait_oe)
  );

endmodule

// File: tb/sim_flash_bus_frontend.sv
module sim_flash_bus_frontend;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 22;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_ce_n = 1'b1, pin_ahold = 1'b1, pin_bclk = 1'b0;
  logic pin_rst_n = 1'b0, pin_we_n = 1'b1;
  logic [AW-1:0] pin_addr = '0;
  logic [DW-1:0] pin_data = '0;
  logic cfg_clk_rise = 1'b1, cfg_wait_early = 1'b0, cfg_sync_mode = 1'b0;
  logic [2:0] cfg_latency = 3'd2;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;
  logic wr_stb, sync_mode, data_valid, wait_o, wait_oe;

  int n_chk = 0, n_bad = 0, stb_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bus_frontend #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .pin_ce_n(pin_ce_n), .pin_ahold(pin_ahold),
    .pin_bclk(pin_bclk), .pin_rst_n(pin_rst_n), .pin_we_n(pin_we_n),
    .pin_addr(pin_addr), .pin_data(pin_data), .cfg_clk_rise(cfg_clk_rise),
    .cfg_wait_early(cfg_wait_early), .cfg_sync_mode(cfg_sync_mode),
    .cfg_latency(cfg_latency), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_stb(wr_stb), .sync_mode(sync_mode),
    .data_valid(data_valid), .wait_o(wait_o), .wait_oe(wait_oe)
  );

  always @(negedge clk) if (!rst && wr_stb) stb_cnt++;

  // burst vectors: [26] rising, [25] early, [24:22] latency, [21:0] address
  localparam logic [26:0] VECS [6] = '{
    {1'b1, 1'b0, 3'd3, 22'h012345},
    {1'b1, 1'b1, 3'd3, 22'h02ABCD},
    {1'b0, 1'b0, 3'd2, 22'h03F0F0},
    {1'b0, 1'b1, 3'd7, 22'h000555},
    {1'b1, 1'b0, 3'd1, 22'h01AAAA},
    {1'b1, 1'b1, 3'd2, 22'h3C0C0C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // four-clock response bound (R11) plus margin
  task automatic settle;
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bclk_toggle;
    pin_bclk = ~pin_bclk;
    settle();
  endtask

  task automatic run_burst(input logic rise, input logic early,
                           input logic [2:0] lat, input logic [AW-1:0] a);
    int le;
    le = (lat < 3'd2) ? 2 : int'(lat);
    pin_ce_n = 1'b1; pin_we_n = 1'b1; pin_ahold = 1'b1;
    settle();
    cfg_clk_rise = rise; cfg_wait_early = early; cfg_latency = lat;
    cfg_sync_mode = 1'b1;
    pin_bclk = rise ? 1'b0 : 1'b1;
    settle();
    pin_ce_n = 1'b0;
    settle();
    chk("R10 mode adopted", 32'(sync_mode), 32'd1);
    chk("R7 no wait before capture", 32'(wait_o), 32'd0);
    pin_addr = a; pin_ahold = 1'b0;
    settle();
    bclk_toggle();
    chk("R5 capture on selected edge", 32'(rd_addr), 32'(a));
    pin_ahold = 1'b1;
    for (int k = 0; k <= le; k++) begin
      if (k > 0) begin
        bclk_toggle();
        bclk_toggle();
      end
      chk("R7 wait level", 32'(wait_o),
          32'(early ? (le - k >= 2) : (le - k >= 1)));
      chk("R6 data valid timing", 32'(data_valid), 32'(k == le));
      chk("R8 wait enable active", 32'(wait_oe), 32'd1);
    end
    pin_addr = ~a; pin_ahold = 1'b0;
    settle();
    chk("R5 no capture without edge", 32'(rd_addr), 32'(a));
    bclk_toggle();
    chk("R5 unselected edge ignored", 32'(rd_addr), 32'(a));
    pin_ahold = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 wait_oe", 32'(wait_oe), 32'd0);
    chk("R1 data_valid", 32'(data_valid), 32'd0);
    chk("R1 rd_addr", 32'(rd_addr), 32'd0);
    chk("R1 wr_stb", 32'(wr_stb), 32'd0);
    rst = 1'b0;
    settle();
    pin_rst_n = 1'b1;
    settle();

    // asynchronous reads
    cfg_sync_mode = 1'b0;
    pin_ce_n = 1'b0;
    settle();
    chk("R3 valid after ce fall", 32'(data_valid), 32'd1);
    chk("R8 enable while active", 32'(wait_oe), 32'd1);
    chk("R10 async mode", 32'(sync_mode), 32'd0);
    for (int i = 0; i < 3; i++) begin
      logic [AW-1:0] a;
      a = AW'(32'h15A5A3 * (i + 1));
      pin_ahold = 1'b0; pin_addr = a;
      settle();
      chk("R4 transparent", 32'(rd_addr), 32'(a));
      pin_ahold = 1'b1; pin_addr = ~a;
      settle();
      chk("R4 held", 32'(rd_addr), 32'(a));
      bclk_toggle();
      bclk_toggle();
      chk("R4 bus clock ignored", 32'(rd_addr), 32'(a));
      chk("R7 no wait async", 32'(wait_o), 32'd0);
    end
    cfg_sync_mode = 1'b1;
    settle();
    chk("R10 no change mid access", 32'(sync_mode), 32'd0);

    // synchronous bursts from the table
    for (int i = 0; i < 6; i++)
      run_burst(VECS[i][26], VECS[i][25], VECS[i][24:22], VECS[i][21:0]);

    // deselect
    pin_ce_n = 1'b1;
    settle();
    chk("R8 enable off when deselected", 32'(wait_oe), 32'd0);
    chk("R8 wait low when deselected", 32'(wait_o), 32'd0);

    // pin reset in the middle of a burst
    cfg_clk_rise = 1'b1; cfg_wait_early = 1'b0; cfg_latency = 3'd7;
    pin_bclk = 1'b0;
    settle();
    pin_ce_n = 1'b0; pin_addr = 22'h2468A; pin_ahold = 1'b0;
    settle();
    bclk_toggle();
    pin_ahold = 1'b1;
    bclk_toggle(); bclk_toggle();
    chk("R7 wait mid burst", 32'(wait_o), 32'd1);
    pin_rst_n = 1'b0;
    settle();
    chk("R2 enable off", 32'(wait_oe), 32'd0);
    chk("R2 wait low", 32'(wait_o), 32'd0);
    chk("R2 valid low", 32'(data_valid), 32'd0);
    chk("R2 mode cleared", 32'(sync_mode), 32'd0);
    chk("R2 address cleared", 32'(rd_addr), 32'd0);
    pin_rst_n = 1'b1;
    settle();
    chk("R2 async after release", 32'(sync_mode), 32'd0);
    chk("R8 enable after release", 32'(wait_oe), 32'd1);
    chk("R3 no valid before edge", 32'(data_valid), 32'd0);
    pin_ahold = 1'b0;
    settle();
    chk("R3 valid after hold fall", 32'(data_valid), 32'd1);
    pin_ahold = 1'b1;

    // write ended by write strobe
    cfg_sync_mode = 1'b0;
    pin_ce_n = 1'b1;
    settle();
    pin_ce_n = 1'b0;
    settle();
    stb_cnt = 0;
    pin_addr = 22'h0BEEF; pin_data = 16'hC3A5; pin_we_n = 1'b0;
    settle();
    pin_we_n = 1'b1;
    settle();
    chk("R9 one pulse on we rise", 32'(stb_cnt), 32'd1);
    chk("R9 write address", 32'(wr_addr), 32'h0BEEF);
    chk("R9 write data", 32'(wr_data), 32'hC3A5);
    pin_ce_n = 1'b1;
    settle();
    chk("R9 no second pulse", 32'(stb_cnt), 32'd1);

    // write ended by chip select
    pin_ce_n = 1'b0;
    settle();
    pin_addr = 22'h31337; pin_data = 16'h5A5A; pin_we_n = 1'b0;
    settle();
    pin_ce_n = 1'b1;
    settle();
    chk("R9 pulse on ce rise", 32'(stb_cnt), 32'd2);
    chk("R9 address on ce rise", 32'(wr_addr), 32'h31337);
    pin_we_n = 1'b1;
    settle();
    chk("R9 we rise after ce ignored", 32'(stb_cnt), 32'd2);

    // bus clock ignored during a write in sync mode
    cfg_sync_mode = 1'b1; cfg_clk_rise = 1'b1;
    pin_bclk = 1'b0;
    settle();
    pin_ce_n = 1'b0;
    settle();
    pin_ahold = 1'b0; pin_addr = 22'h11111;
    settle();
    bclk_toggle();
    chk("R5 sync capture", 32'(rd_addr), 32'h11111);
    bclk_toggle();
    pin_we_n = 1'b0; pin_addr = 22'h22222;
    settle();
    bclk_toggle();
    chk("R9 clock ignored in write", 32'(rd_addr), 32'h11111);
    pin_we_n = 1'b1; pin_ahold = 1'b1;
    settle();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule